// File: doc/BRIEF.md
# Notification Record Timestamp Stamper

The stamper takes short notification payloads from several producer lanes and turns each one into a fixed 128-bit record for a downstream ring writer. A 64-bit free-running timestamp advances by a programmable amount on every clock. Its value at the moment a lane accepts a payload is stored with that payload. When the record leaves the block, a header byte is built from four parts: the type code, two sticky loss flags and the ring phase bit. The ring writer supplies the phase bit for each destination.

Each lane has a small buffer and two control bits: an enable bit, and a policy bit that chooses between stalling the producer and discarding the record when the buffer is full. When records are lost, a flag is carried forward on a later record. A drop in a lane buffer sets the hardware-loss flag for that lane. A loss that the ring writer reports for a destination sets the software-loss flag for that destination. A round-robin arbiter moves at most one record per cycle into a registered output slot with a valid/ready handshake. A read-to-clear counter tallies the records handed off.

Top module: `notif_stamper`

## Requirements
- R1: After reset the timestamp is 0 and the per-clock step is 0x400. Each clock adds the step to the timestamp. A write of a new step (`ts_inc_we`) takes effect on the clock that follows the write.
- R2: A `ts_clear` strobe makes the timestamp read 0 after that clock edge, whatever the step.
- R3: Record bits [127:64] hold the timestamp value seen in the cycle the lane accepted the payload. Bits [63:32] carry `prod_hi` and bits [23:0] carry `prod_lo`, both unchanged. Bits [28:24] carry the 5-bit `prod_kind`. `rec_dest` equals `prod_dest`.
- R4: Record bit [31] is the phase bit. It follows `ring_phase[rec_dest]` while the record is presented.
- R5: If a lane's buffer (`BUF_DEPTH` entries) is full and its `lane_stall` bit is 1, the lane drops `prod_ready` and `stall_evt` bit i is high for as long as valid is held. The held record is accepted later and none is lost.
- R6: If a lane's buffer is full and its `lane_stall` bit is 0, `prod_ready` stays 1 and the record is discarded. In that cycle `drop_evt` bit i is high.
- R7: After a discard on lane i, the next record that lane i emits has bit [30] set. Records after that one have bit [30] clear until another discard.
- R8: A `ring_lost` pulse with destination d sets bit [29] on the next record emitted for destination d, and on that record only.
- R9: When `lane_en` bit i is 0, lane i holds `prod_ready` at 1, discards its records, and raises no stall or drop events.
- R10: `emit_cnt` counts output handshakes. In the cycle `emit_cnt_rd` is high it shows the total so far, and on the next clock it restarts from 0 (or from 1 if a handshake happens in that cycle).
- R11: After the arbiter grants lane i, the next grant goes to the first lane that holds a record, searching i+1, i+2, … and wrapping around.
- R12: While `rec_valid` is 1 and `rec_ready` is 0, `rec_valid`, `rec_dest` and every record bit except the phase bit [31] stay unchanged.
- R13: While reset is asserted, `rec_valid` is 0, `emit_cnt` is 0, the timestamp is 0, and no stall or drop event is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ts_inc_we | input | 1 | Load a new timestamp step |
| ts_inc_wdata | input | 24 | New timestamp step |
| ts_clear | input | 1 | Clear the timestamp |
| ts_now | output | 64 | Current timestamp |
| lane_en | input | NUM_IN | Per-lane enable |
| lane_stall | input | NUM_IN | Per-lane full policy: 1 stall, 0 drop |
| prod_valid | input | NUM_IN | Producer valid per lane |
| prod_ready | output | NUM_IN | Producer ready per lane |
| prod_kind | input | NUM_IN×5 | Type code per lane |
| prod_lo | input | NUM_IN×24 | Low payload per lane |
| prod_hi | input | NUM_IN×32 | High payload per lane |
| prod_dest | input | NUM_IN×DEST_W | Destination queue per lane |
| stall_evt | output | NUM_IN | Stall event per lane |
| drop_evt | output | NUM_IN | Drop event per lane |
| ring_lost | input | 1 | Ring writer reports a lost record |
| ring_lost_dest | input | DEST_W | Destination of the lost record |
| ring_phase | input | NUM_DEST | Phase bit per destination |
| rec_valid | output | 1 | Record valid |
| rec_ready | input | 1 | Record ready |
| rec_data | output | 128 | Assembled record |
| rec_dest | output | DEST_W | Record destination |
| emit_cnt_rd | input | 1 | Read strobe that clears the counter |
| emit_cnt | output | 32 | Emitted-record count |

## Verification
The bench builds the block with four lanes, two-entry buffers and four destinations. With two-entry buffers, three sends are enough to fill a lane: one record sits in the output slot and two in the buffer. That makes the stall and drop policies and the hardware-loss flag reachable in a few cycles. With three backlogged lanes out of four, the round-robin pointer has to wrap across the whole lane index range. With four destinations, a software-loss flag on one destination can be checked against records sent to a neighbouring destination.

// File: rtl/stamper_pkg.sv
`timescale 1ns/1ps
package stamper_pkg;
  localparam int KIND_W = 5;
  localparam int LO_W   = 24;
  localparam int HI_W   = 32;
  localparam int TS_W   = 64;
  localparam int INC_W  = 24;
  localparam int REC_W  = 128;
  localparam logic [INC_W-1:0] INC_RST = 24'h000400;

  // one buffered entry: payload plus the captured timestamp
  typedef struct packed {
    logic [KIND_W-1:0] kind;
    logic [LO_W-1:0]   lo;
    logic [HI_W-1:0]   hi;
    logic [TS_W-1:0]   ts;
  } slot_t;

  // header byte, msb first: phase, hw loss, sw loss, type
  typedef struct packed {
    logic              phase;
    logic              hw_loss;
    logic              sw_loss;
    logic [KIND_W-1:0] kind;
  } hdr_t;

  function automatic logic [REC_W-1:0] pack_rec(hdr_t h, slot_t s);
    return {s.ts, s.hi, h, s.lo};
  endfunction
endpackage

// File: rtl/stamp_clock.sv
`timescale 1ns/1ps
module stamp_clock
  import stamper_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_we,
  input  logic [INC_W-1:0] inc_wdata,
  input  logic             clr,
  output logic [TS_W-1:0]  ts_o
);
  logic [INC_W-1:0] inc_q, inc_d;
  logic [TS_W-1:0]  ts_q, ts_d;

  always_comb begin
    inc_d = inc_q;
    if (inc_we) inc_d = inc_wdata;
    ts_d = clr ? '0 : ts_q + TS_W'(inc_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inc_q <= INC_RST;
      ts_q  <= '0;
    end else begin
      inc_q <= inc_d;
      ts_q  <= ts_d;
    end
  end

  assign ts_o = ts_q;
endmodule

// File: rtl/stamp_lane.sv
`timescale 1ns/1ps
module stamp_lane
  import stamper_pkg::*;
#(
  parameter int DEPTH  = 2,
  parameter int DEST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              stall_mode,
  input  logic              push_valid,
  input  slot_t             push_slot,
  input  logic [DEST_W-1:0] push_dest,
  output logic              push_ready,
  input  logic              pop,
  output slot_t             head_slot,
  output logic [DEST_W-1:0] head_dest,
  output logic              has_data,
  output logic              stall_evt,
  output logic              drop_evt,
  output logic              loss_flag
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  slot_t             mem_q  [DEPTH];
  logic [DEST_W-1:0] dmem_q [DEPTH];
  logic [AW-1:0]     wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic              loss_q, loss_d;
  logic              live, full, wr;

  function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    live       = push_valid & en;
    full       = (cnt_q == CW'(DEPTH));
    push_ready = ~en | ~full | ~stall_mode;
    wr         = live & ~full;
    stall_evt  = live & full & stall_mode;
    drop_evt   = live & full & ~stall_mode;
    wp_d       = wr  ? bump(wp_q) : wp_q;
    rp_d       = pop ? bump(rp_q) : rp_q;
    cnt_d      = cnt_q + CW'(wr) - CW'(pop);
    // a fresh drop wins over the clear on emission
    loss_d     = drop_evt ? 1'b1 : (pop ? 1'b0 : loss_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q   <= '0;
      rp_q   <= '0;
      cnt_q  <= '0;
      loss_q <= 1'b0;
    end else begin
      wp_q   <= wp_d;
      rp_q   <= rp_d;
      cnt_q  <= cnt_d;
      loss_q <= loss_d;
    end
  end

  // storage carries no reset; only written entries are read
  always_ff @(posedge clk) begin
    if (wr) begin
      mem_q[wp_q]  <= push_slot;
      dmem_q[wp_q] <= push_dest;
    end
  end

  assign head_slot = mem_q[rp_q];
  assign head_dest = dmem_q[rp_q];
  assign has_data  = (cnt_q != '0);
  assign loss_flag = loss_q;
endmodule

// File: rtl/stamp_rr.sv
`timescale 1ns/1ps
module stamp_rr #(
  parameter  int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          adv,
  output logic [IW-1:0] gnt,
  output logic          any
);
  logic [IW-1:0] last_q, last_d;

  always_comb begin
    gnt = last_q;
    any = 1'b0;
    for (int k = 1; k <= N; k++) begin
      int c;
      c = int'(last_q) + k;
      if (c >= N) c = c - N;
      if (!any && req[IW'(c)]) begin
        any = 1'b1;
        gnt = IW'(c);
      end
    end
    last_d = adv ? gnt : last_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= IW'(N - 1);
    else        last_q <= last_d;
  end
endmodule

// File: rtl/notif_stamper.sv
`timescale 1ns/1ps
module notif_stamper
  import stamper_pkg::*;
#(
  parameter  int NUM_IN    = 4,
  parameter  int BUF_DEPTH = 2,
  parameter  int NUM_DEST  = 4,
  localparam int DEST_W    = (NUM_DEST > 1) ? $clog2(NUM_DEST) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           ts_inc_we,
  input  logic [23:0]                    ts_inc_wdata,
  input  logic                           ts_clear,
  output logic [63:0]                    ts_now,
  input  logic [NUM_IN-1:0]              lane_en,
  input  logic [NUM_IN-1:0]              lane_stall,
  input  logic [NUM_IN-1:0]              prod_valid,
  output logic [NUM_IN-1:0]              prod_ready,
  input  logic [NUM_IN-1:0][4:0]         prod_kind,
  input  logic [NUM_IN-1:0][23:0]        prod_lo,
  input  logic [NUM_IN-1:0][31:0]        prod_hi,
  input  logic [NUM_IN-1:0][DEST_W-1:0]  prod_dest,
  output logic [NUM_IN-1:0]              stall_evt,
  output logic [NUM_IN-1:0]              drop_evt,
  input  logic                           ring_lost,
  input  logic [DEST_W-1:0]              ring_lost_dest,
  input  logic [NUM_DEST-1:0]            ring_phase,
  output logic                           rec_valid,
  input  logic                           rec_ready,
  output logic [127:0]                   rec_data,
  output logic [DEST_W-1:0]              rec_dest,
  input  logic                           emit_cnt_rd,
  output logic [31:0]                    emit_cnt
);
  localparam int IW = (NUM_IN > 1) ? $clog2(NUM_IN) : 1;

  // ---------------- timestamp ----------------
  stamp_clock u_clock (
    .clk       (clk),
    .rst_n     (rst_n),
    .inc_we    (ts_inc_we),
    .inc_wdata (ts_inc_wdata),
    .clr       (ts_clear),
    .ts_o      (ts_now)
  );

  // ---------------- lanes ----------------
  slot_t             head_slot [NUM_IN];
  logic [DEST_W-1:0] head_dest [NUM_IN];
  logic [NUM_IN-1:0] has_data, hw_loss, pop_vec;

  for (genvar g = 0; g < NUM_IN; g++) begin : g_lane
    slot_t in_slot;
    assign in_slot = '{kind: prod_kind[g], lo: prod_lo[g], hi: prod_hi[g], ts: ts_now};

    stamp_lane #(
      .DEPTH  (BUF_DEPTH),
      .DEST_W (DEST_W)
    ) u_lane (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (lane_en[g]),
      .stall_mode (lane_stall[g]),
      .push_valid (prod_valid[g]),
      .push_slot  (in_slot),
      .push_dest  (prod_dest[g]),
      .push_ready (prod_ready[g]),
      .pop        (pop_vec[g]),
      .head_slot  (head_slot[g]),
      .head_dest  (head_dest[g]),
      .has_data   (has_data[g]),
      .stall_evt  (stall_evt[g]),
      .drop_evt   (drop_evt[g]),
      .loss_flag  (hw_loss[g])
    );
  end

  // ---------------- arbitration ----------------
  logic [IW-1:0] gnt;
  logic          any, load, adv;

  stamp_rr #(.N(NUM_IN)) u_rr (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (has_data),
    .adv   (adv),
    .gnt   (gnt),
    .any   (any)
  );

  logic              out_v_q, out_v_d;
  slot_t             out_slot_q;
  logic [DEST_W-1:0] out_dest_q, sel_dest;
  logic              out_hw_q, out_sw_q;
  logic [NUM_DEST-1:0] sw_q, sw_d, sw_set, sw_clr;
  logic [31:0]       cnt_q, cnt_d;
  logic              hs;

  always_comb begin
    load     = ~out_v_q | rec_ready;
    adv      = load & any;
    pop_vec  = adv ? (NUM_IN'(1) << gnt) : '0;
    sel_dest = head_dest[gnt];
    out_v_d  = load ? any : out_v_q;
    // sticky per-destination software loss flags, set wins
    sw_set   = ring_lost ? (NUM_DEST'(1) << ring_lost_dest) : '0;
    sw_clr   = adv ? (NUM_DEST'(1) << sel_dest) : '0;
    sw_d     = sw_set | (sw_q & ~sw_clr);
    hs       = out_v_q & rec_ready;
    cnt_d    = emit_cnt_rd ? 32'(hs) : cnt_q + 32'(hs);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_v_q <= 1'b0;
      sw_q    <= '0;
      cnt_q   <= '0;
    end else begin
      out_v_q <= out_v_d;
      sw_q    <= sw_d;
      cnt_q   <= cnt_d;
    end
  end

  // output data registers, loaded only when a record is taken
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_slot_q <= '0;
      out_dest_q <= '0;
      out_hw_q   <= 1'b0;
      out_sw_q   <= 1'b0;
    end else if (adv) begin
      out_slot_q <= head_slot[gnt];
      out_dest_q <= sel_dest;
      out_hw_q   <= hw_loss[gnt];
      out_sw_q   <= sw_q[sel_dest];
    end
  end

  hdr_t hdr;
  always_comb begin
    hdr.phase   = ring_phase[out_dest_q];
    hdr.hw_loss = out_hw_q;
    hdr.sw_loss = out_sw_q;
    hdr.kind    = out_slot_q.kind;
  end

  assign rec_valid = out_v_q;
  assign rec_data  = pack_rec(hdr, out_slot_q);
  assign rec_dest  = out_dest_q;
  assign emit_cnt  = cnt_q;
endmodule

// File: rtl/notif_stamper_chk.sv
`timescale 1ns/1ps
module notif_stamper_chk #(
  parameter  int NUM_IN   = 4,
  parameter  int NUM_DEST = 4,
  localparam int DEST_W   = (NUM_DEST > 1) ? $clog2(NUM_DEST) : 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                ts_inc_we,
  input logic [23:0]         ts_inc_wdata,
  input logic                ts_clear,
  input logic [63:0]         ts_now,
  input logic [NUM_IN-1:0]   lane_en,
  input logic [NUM_IN-1:0]   prod_ready,
  input logic [NUM_IN-1:0]   stall_evt,
  input logic [NUM_IN-1:0]   drop_evt,
  input logic                rec_valid,
  input logic                rec_ready,
  input logic [127:0]        rec_data,
  input logic [DEST_W-1:0]   rec_dest,
  input logic                emit_cnt_rd,
  input logic [31:0]         emit_cnt
);
  logic        armed;
  logic [23:0] step_model;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed      <= 1'b0;
      step_model <= 24'h000400;
    end else begin
      armed      <= 1'b1;
      if (ts_inc_we) step_model <= ts_inc_wdata;
    end
  end

  assert_ts_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !$past(ts_clear) |-> ts_now == $past(ts_now) + 64'($past(step_model)));

  assert_ts_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(ts_clear) |-> ts_now == 64'd0);

  assert_stall_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_evt & prod_ready) == '0);

  assert_drop_accepts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((drop_evt & ~prod_ready) == '0) && ((drop_evt & stall_evt) == '0));

  assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((stall_evt | drop_evt) & ~lane_en) == '0);

  assert_count_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(emit_cnt_rd) |-> emit_cnt <= 32'd1);

  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && !rec_ready |=> rec_valid && $stable(rec_data[127:32])
      && $stable(rec_data[30:0]) && $stable(rec_dest));

  assert_reset_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !rec_valid && emit_cnt == 32'd0);
endmodule

bind notif_stamper notif_stamper_chk #(
  .NUM_IN   (NUM_IN),
  .NUM_DEST (NUM_DEST)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ts_inc_we    (ts_inc_we),
  .ts_inc_wdata (ts_inc_wdata),
  .ts_clear     (ts_clear),
  .ts_now       (ts_now),
  .lane_en      (lane_en),
  .prod_ready   (prod_ready),
  .stall_evt    (stall_evt),
  .drop_evt     (drop_evt),
  .rec_valid    (rec_valid),
  .rec_ready    (rec_ready),
  .rec_data     (rec_data),
  .rec_dest     (rec_dest),
  .emit_cnt_rd  (emit_cnt_rd),
  .emit_cnt     (emit_cnt)
);

// File: tb/tb_notif_stamper.sv
`timescale 1ns/1ps
module tb_notif_stamper;
  localparam int NI = 4;
  localparam int ND = 4;
  localparam int DW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic                   ts_inc_we = 1'b0;
  logic [23:0]            ts_inc_wdata = '0;
  logic                   ts_clear = 1'b0;
  logic [63:0]            ts_now;
  logic [NI-1:0]          lane_en = '1;
  logic [NI-1:0]          lane_stall = 4'b0001;
  logic [NI-1:0]          prod_valid = '0;
  logic [NI-1:0]          prod_ready;
  logic [NI-1:0][4:0]     prod_kind = '0;
  logic [NI-1:0][23:0]    prod_lo = '0;
  logic [NI-1:0][31:0]    prod_hi = '0;
  logic [NI-1:0][DW-1:0]  prod_dest = '0;
  logic [NI-1:0]          stall_evt, drop_evt;
  logic                   ring_lost = 1'b0;
  logic [DW-1:0]          ring_lost_dest = '0;
  logic [ND-1:0]          ring_phase = '0;
  logic                   rec_valid;
  logic                   rec_ready = 1'b1;
  logic [127:0]           rec_data;
  logic [DW-1:0]          rec_dest;
  logic                   emit_cnt_rd = 1'b0;
  logic [31:0]            emit_cnt;

  notif_stamper #(.NUM_IN(NI), .BUF_DEPTH(2), .NUM_DEST(ND)) dut (.*);

  int n_chk = 0;
  int n_err = 0;
  int n_emit = 0;
  logic [127:0]  got_q [$];
  logic [DW-1:0] gotd_q [$];

  // capture every handshake late in the low phase
  always @(negedge clk) begin
    #2;
    if (rst_n && rec_valid && rec_ready) begin
      got_q.push_back(rec_data);
      gotd_q.push_back(rec_dest);
      n_emit++;
    end
  end

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic send(input int i, input logic [4:0] k, input logic [23:0] lo,
                      input logic [31:0] hi, input logic [DW-1:0] d, output logic [63:0] ts);
    prod_valid[i] = 1'b1;
    prod_kind[i]  = k;
    prod_lo[i]    = lo;
    prod_hi[i]    = hi;
    prod_dest[i]  = d;
    #0.1;
    ts = ts_now;
    step();
    prod_valid[i] = 1'b0;
  endtask

  task automatic wait_rec(output logic [127:0] r, output logic [DW-1:0] d);
    int n = 0;
    while (got_q.size() == 0 && n < 40) begin
      step();
      n++;
    end
    if (got_q.size() == 0) begin
      r = 'x;
      d = 'x;
    end else begin
      r = got_q.pop_front();
      d = gotd_q.pop_front();
    end
  endtask

  // vector: lane[64:63] kind[62:58] lo[57:34] hi[33:2] dest[1:0]
  localparam logic [64:0] VEC [6] = '{
    {2'd0, 5'h04, 24'h123456, 32'hdeadbeef, 2'd1},
    {2'd1, 5'h1f, 24'hffffff, 32'h00000000, 2'd0},
    {2'd2, 5'h02, 24'h000000, 32'hffffffff, 2'd3},
    {2'd3, 5'h17, 24'ha5a5a5, 32'h5a5a5a5a, 2'd2},
    {2'd0, 5'h00, 24'h0f0f0f, 32'h12345678, 2'd3},
    {2'd2, 5'h11, 24'h800001, 32'h80000001, 2'd0}
  };

  initial begin
    #1_000_000;
    n_err++;
    $display("FAIL watchdog: actual running expected finished");
    finish_up();
  end

  initial begin
    logic [63:0]  t0, t1, ts;
    logic [127:0] r, snap;
    logic [DW-1:0] d;
    logic [3:0]   src [6];

    // R13: reset state
    step();
    chk("R13 rec_valid", 128'(rec_valid), 128'd0);
    chk("R13 emit_cnt", 128'(emit_cnt), 128'd0);
    chk("R13 ts_now", 128'(ts_now), 128'd0);
    chk("R13 events", 128'(stall_evt | drop_evt), 128'd0);
    rst_n = 1'b1;
    step();

    // R1: default step 0x400, then a written step
    t0 = ts_now; step(); t1 = ts_now;
    chk("R1 default step", 128'(t1 - t0), 128'h400);
    ts_inc_we = 1'b1; ts_inc_wdata = 24'h000010;
    step();
    ts_inc_we = 1'b0;
    t0 = ts_now; step(); t1 = ts_now;
    chk("R1 written step", 128'(t1 - t0), 128'h10);

    // R2: clear strobe
    ts_clear = 1'b1;
    step();
    ts_clear = 1'b0;
    chk("R2 cleared", 128'(ts_now), 128'd0);
    step();
    chk("R2 resumes", 128'(ts_now), 128'h10);

    // R3: table of records
    for (int v = 0; v < 6; v++) begin
      logic [64:0] e;
      e = VEC[v];
      send(int'(e[64:63]), e[62:58], e[57:34], e[33:2], e[1:0], ts);
      wait_rec(r, d);
      chk($sformatf("R3 record %0d", v), r, {ts, e[33:2], 3'b000, e[62:58], e[57:34]});
      chk($sformatf("R3 dest %0d", v), 128'(d), 128'(e[1:0]));
    end

    // R4: phase bit follows destination
    ring_phase = 4'b0100;
    send(2, 5'h05, 24'h1, 32'h1, 2'd2, ts);
    wait_rec(r, d);
    chk("R4 phase set", 128'(r[31]), 128'd1);
    send(2, 5'h05, 24'h2, 32'h2, 2'd1, ts);
    wait_rec(r, d);
    chk("R4 phase clear", 128'(r[31]), 128'd0);
    ring_phase = '0;

    // R8: software loss flag on destination 2 only, once
    ring_lost = 1'b1; ring_lost_dest = 2'd2;
    step();
    ring_lost = 1'b0;
    send(0, 5'h06, 24'h31, 32'h0, 2'd3, ts);
    send(0, 5'h06, 24'h32, 32'h0, 2'd2, ts);
    send(0, 5'h06, 24'h33, 32'h0, 2'd2, ts);
    wait_rec(r, d); chk("R8 other dest", 128'(r[29]), 128'd0);
    wait_rec(r, d); chk("R8 flagged", 128'(r[29]), 128'd1);
    wait_rec(r, d); chk("R8 cleared", 128'(r[29]), 128'd0);

    // R5 and R12: stall policy on lane 0
    repeat (3) step();
    rec_ready = 1'b0;
    send(0, 5'h07, 24'hA1, 32'h0, 2'd0, ts);
    send(0, 5'h07, 24'hA2, 32'h0, 2'd0, ts);
    send(0, 5'h07, 24'hA3, 32'h0, 2'd0, ts);
    prod_valid[0] = 1'b1; prod_lo[0] = 24'hA4;
    #0.1;
    chk("R5 ready low", 128'(prod_ready[0]), 128'd0);
    chk("R5 stall event", 128'(stall_evt), 128'b0001);
    snap = rec_data;
    step();
    chk("R12 valid held", 128'(rec_valid), 128'd1);
    chk("R12 data held", rec_data, snap);
    rec_ready = 1'b1;
    for (int n = 0; n < 10 && !prod_ready[0]; n++) step();
    step();
    prod_valid[0] = 1'b0;
    for (int n = 1; n <= 4; n++) begin
      wait_rec(r, d);
      chk($sformatf("R5 order %0d", n), 128'(r[23:0]), 128'(24'hA0 + n));
    end

    // R6 and R7: drop policy on lane 1
    repeat (3) step();
    rec_ready = 1'b0;
    send(1, 5'h08, 24'hB1, 32'h0, 2'd1, ts);
    send(1, 5'h08, 24'hB2, 32'h0, 2'd1, ts);
    send(1, 5'h08, 24'hB3, 32'h0, 2'd1, ts);
    prod_valid[1] = 1'b1; prod_lo[1] = 24'hB4;
    #0.1;
    chk("R6 ready high", 128'(prod_ready[1]), 128'd1);
    chk("R6 drop event", 128'(drop_evt), 128'b0010);
    step();
    prod_valid[1] = 1'b0;
    rec_ready = 1'b1;
    wait_rec(r, d); chk("R7 before drop", 128'({r[30], r[23:0]}), 128'({1'b0, 24'hB1}));
    wait_rec(r, d); chk("R7 flagged", 128'({r[30], r[23:0]}), 128'({1'b1, 24'hB2}));
    wait_rec(r, d); chk("R7 cleared", 128'({r[30], r[23:0]}), 128'({1'b0, 24'hB3}));
    repeat (6) step();
    chk("R6 record lost", 128'(got_q.size()), 128'd0);

    // R9: disabled lane 3
    lane_en[3] = 1'b0;
    prod_valid[3] = 1'b1; prod_lo[3] = 24'hC1;
    #0.1;
    chk("R9 ready high", 128'(prod_ready[3]), 128'd1);
    chk("R9 no events", 128'(stall_evt | drop_evt), 128'd0);
    repeat (3) step();
    prod_valid[3] = 1'b0;
    repeat (6) step();
    chk("R9 nothing emitted", 128'(got_q.size()), 128'd0);
    lane_en[3] = 1'b1;

    // R11: round robin over three backlogged lanes
    for (int c = 0; c < 2; c++) begin
      for (int i = 0; i < 3; i++) begin
        prod_valid[i] = 1'b1;
        prod_lo[i]    = 24'(16 * c + i);
      end
      step();
    end
    prod_valid = '0;
    for (int k = 0; k < 6; k++) begin
      wait_rec(r, d);
      src[k] = r[3:0];
    end
    for (int k = 0; k < 3; k++)
      chk($sformatf("R11 rotation %0d", k), 128'(src[k + 3]), 128'(src[k]));
    chk("R11 distinct", 128'((src[0] != src[1]) && (src[1] != src[2]) && (src[0] != src[2])), 128'd1);

    // R10: read-to-clear counter
    repeat (4) step();
    emit_cnt_rd = 1'b1;
    #0.1;
    chk("R10 total", 128'(emit_cnt), 128'(n_emit));
    step();
    emit_cnt_rd = 1'b0;
    chk("R10 cleared", 128'(emit_cnt), 128'd0);
    send(2, 5'h09, 24'hD1, 32'h0, 2'd0, ts);
    repeat (4) step();
    chk("R10 recount", 128'(emit_cnt), 128'd1);

    finish_up();
  end
endmodule